// File: doc/BRIEF.md
# Multithreaded Fetch Thread Selector

This block decides, every clock cycle, which hardware thread feeds the next instruction into a shared single-issue pipeline. It keeps a program counter for each thread. It reports the chosen thread, the address to fetch and a valid bit, and it asks for a pipeline flush when the running thread is replaced. Caches, decode, register files and execution units sit outside it.

Two scheduling modes are available. In interleaved mode (`mode_coarse` low) the block rotates over the threads in round-robin order, one fetch per cycle. A thread whose short-stall or long-stall flag is high is skipped. In block mode (`mode_coarse` high) one thread keeps the pipeline until it reports a long-latency stall. The block then spends one decision cycle and one flush cycle, and after that the new thread refills the pipeline from its own program counter. In both modes a preferred thread can be enabled. That thread takes the slot whenever it is ready.

The controller is a three-state machine. `SEL_FINE` is interleaved fetching and is also the reset state. `SEL_CFLUSH` is the single flush cycle. `SEL_CRUN` means block mode, running the current thread. The transitions are:
- FINE→CFLUSH when block mode is selected. The current thread becomes the one the round-robin pointer names.
- CFLUSH→CRUN while block mode stays selected.
- CFLUSH→FINE when block mode has been dropped.
- CRUN→CFLUSH on a switch, which is a long stall of the current thread while another thread is ready, or the preferred thread becoming ready.
- CRUN→FINE when block mode is dropped.
- Every state loops to itself otherwise.

Top module: `mt_fetch_sel`

## Requirements
- R1: A synchronous active-high reset sets every thread PC to `RESET_PC`, the round-robin pointer to thread 0 and the state to `SEL_FINE`, with `flush_req` low. With all threads ready, the first fetch after reset is thread 0 at `RESET_PC`.
- R2: In interleaved mode, with every thread ready and no preference, consecutive fetches visit the threads in ascending ID order (0,1,2,3,0,...). `fetch_tid` is the binary thread number.
- R3: In interleaved mode a thread whose `short_stall` or `long_stall` bit is high is skipped, and only ready threads are fetched.
- R4: When no thread is ready, `fetch_vld` is low and the round-robin pointer holds, so the next fetch comes from the thread after the last one fetched.
- R5: Each valid fetch advances that thread's PC by `PC_STEP`, and the PCs of the other threads are unchanged.
- R6: A valid redirect for a thread replaces its PC in that cycle. If the thread is fetched in that cycle, `fetch_pc` shows the redirect address and the stored PC becomes redirect + `PC_STEP`. The redirect takes priority over the increment.
- R7: Selecting block mode from interleaved mode gives one cycle with no fetch and then one flush cycle. After that the pointed-to thread fetches on every cycle, and a short stall only pauses it (no fetch, no flush, no switch).
- R8: In block mode a long stall of the current thread, while another thread is ready, gives one cycle with no fetch and then `flush_req` high for exactly one cycle with `fetch_vld` low. The next ready thread after the pointer then fetches from its own PC.
- R9: In block mode, if the current thread long-stalls and no other thread is ready, there is no flush. The block waits and resumes the same thread when its stall clears.
- R10: In interleaved mode, with `pref_en` high and the thread `pref_tid` ready, that thread is fetched every cycle. Others are fetched only while it stalls, and preferred fetches do not move the round-robin pointer.
- R11: In block mode, with `pref_en` high, the preferred thread becoming ready while another thread runs causes a switch to it through the same no-fetch and flush sequence as R8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_coarse | input | 1 | 0 = interleaved every cycle, 1 = switch on long stall |
| pref_en | input | 1 | Enable preferred-thread priority |
| pref_tid | input | TID_W | Preferred thread number |
| short_stall | input | NUM_THR | Per-thread short stall flag |
| long_stall | input | NUM_THR | Per-thread long-latency stall flag |
| redir_vld | input | NUM_THR | Per-thread redirect valid |
| redir_pc | input | NUM_THR*PC_W | Per-thread redirect address, thread i in bits [i*PC_W +: PC_W] |
| fetch_vld | output | 1 | An instruction is fetched this cycle |
| fetch_tid | output | TID_W | Selected thread number |
| fetch_pc | output | PC_W | Fetch address of the selected thread |
| flush_req | output | 1 | Pipeline flush request, one cycle per switch |

## Verification
The bench builds the block with its default parameters: four threads, 32-bit PCs, a step of 4 and a reset vector of 0x100. With four threads, the bench can stall two threads at once and still see wraparound between the remaining two. It can also exercise a preferred thread that is neither the first nor the last, and a block-mode switch that must pass over the stalled current thread. The directed scenarios check PC continuity across switches by predicting every thread's next address from its own fetch history.

// File: rtl/mtf_pkg.sv
package mtf_pkg;

    typedef enum logic [1:0] {
        SEL_FINE   = 2'd0,
        SEL_CFLUSH = 2'd1,
        SEL_CRUN   = 2'd2
    } sel_state_e;

endpackage

// File: rtl/mtf_rr_pick.sv
module mtf_rr_pick #(
    parameter int unsigned NUM_THR = 4,
    parameter int unsigned TID_W   = 2
) (
    input  logic [NUM_THR-1:0] cand,
    input  logic [TID_W-1:0]   start,
    output logic [TID_W-1:0]   pick,
    output logic               found
);

    // Search from start upward with wraparound; the nearest candidate wins.
    always_comb begin
        found = 1'b0;
        pick  = start;
        for (int k = NUM_THR - 1; k >= 0; k--) begin
            int s;
            s = int'(start) + k;
            if (s >= int'(NUM_THR)) begin
                s = s - int'(NUM_THR);
            end
            if (cand[s]) begin
                pick  = TID_W'(s);
                found = 1'b1;
            end
        end
    end

endmodule

// File: rtl/mtf_pc_bank.sv
module mtf_pc_bank #(
    parameter int unsigned     NUM_THR  = 4,
    parameter int unsigned     TID_W    = 2,
    parameter int unsigned     PC_W     = 32,
    parameter logic [PC_W-1:0] RESET_PC = 'h100,
    parameter int unsigned     PC_STEP  = 4
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    fire,
    input  logic [TID_W-1:0]        fire_tid,
    input  logic [NUM_THR-1:0]      redir_vld,
    input  logic [NUM_THR*PC_W-1:0] redir_pc,
    output logic [PC_W-1:0]         rd_pc
);

    logic [PC_W-1:0] pc_q [NUM_THR];
    logic [PC_W-1:0] eff  [NUM_THR];

    for (genvar g = 0; g < NUM_THR; g++) begin : g_thr
        logic hit;

        assign eff[g] = redir_vld[g] ? redir_pc[g*PC_W +: PC_W] : pc_q[g];
        assign hit    = fire && (fire_tid == TID_W'(g));

        always_ff @(posedge clk) begin
            if (rst) begin
                pc_q[g] <= RESET_PC;
            end else if (hit) begin
                pc_q[g] <= eff[g] + PC_W'(PC_STEP);
            end else begin
                pc_q[g] <= eff[g];
            end
        end

        // R5: a fetch without redirect moves this PC on by one step
        a_r5_pc_step: assert property (@(posedge clk) disable iff (rst)
            (hit && !redir_vld[g]) |=> (pc_q[g] == $past(pc_q[g]) + PC_W'(PC_STEP)));

        // R6: an unfetched redirect lands unchanged in the PC
        a_r6_redir_load: assert property (@(posedge clk) disable iff (rst)
            (redir_vld[g] && !hit) |=> (pc_q[g] == $past(redir_pc[g*PC_W +: PC_W])));

        // R5: an idle thread without redirect keeps its PC
        a_r5_pc_hold: assert property (@(posedge clk) disable iff (rst)
            (!redir_vld[g] && !hit) |=> $stable(pc_q[g]));
    end

    assign rd_pc = eff[fire_tid];

endmodule

// File: rtl/mtf_ctrl.sv
module mtf_ctrl
    import mtf_pkg::*;
#(
    parameter int unsigned NUM_THR = 4,
    parameter int unsigned TID_W   = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               mode_coarse,
    input  logic               pref_en,
    input  logic [TID_W-1:0]   pref_tid,
    input  logic [NUM_THR-1:0] ready,
    input  logic [NUM_THR-1:0] long_stall,
    input  logic [TID_W-1:0]   pick,
    input  logic               found,
    output logic [NUM_THR-1:0] excl,
    output logic [TID_W-1:0]   rr_ptr,
    output logic               fetch_vld,
    output logic [TID_W-1:0]   fetch_tid,
    output logic               flush_req
);

    sel_state_e       st_q, st_d;
    logic [TID_W-1:0] cur_q, cur_d;
    logic [TID_W-1:0] rr_q, rr_d;

    logic pref_hit;
    logic pref_other;
    logic cur_ready;
    logic cur_long;

    function automatic logic [TID_W-1:0] tid_inc(input logic [TID_W-1:0] t);
        if (int'(t) == int'(NUM_THR) - 1) begin
            return '0;
        end
        return t + TID_W'(1);
    endfunction

    assign pref_hit   = pref_en && ready[pref_tid];
    assign pref_other = pref_hit && (pref_tid != cur_q);
    assign cur_ready  = ready[cur_q];
    assign cur_long   = long_stall[cur_q];

    // In block mode the running thread is not a switch target.
    for (genvar g = 0; g < NUM_THR; g++) begin : g_excl
        assign excl[g] = (st_q == SEL_CRUN) && (cur_q == TID_W'(g));
    end

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= SEL_FINE;
            cur_q <= '0;
            rr_q  <= '0;
        end else begin
            st_q  <= st_d;
            cur_q <= cur_d;
            rr_q  <= rr_d;
        end
    end

    // Next-state logic
    always_comb begin
        st_d  = st_q;
        cur_d = cur_q;
        rr_d  = rr_q;
        unique case (st_q)
            SEL_FINE: begin
                if (mode_coarse) begin
                    st_d  = SEL_CFLUSH;
                    cur_d = rr_q;
                end else if (!pref_hit && found) begin
                    rr_d = tid_inc(pick);
                end
            end
            SEL_CFLUSH: begin
                st_d = mode_coarse ? SEL_CRUN : SEL_FINE;
            end
            SEL_CRUN: begin
                if (!mode_coarse) begin
                    st_d = SEL_FINE;
                end else if (pref_other) begin
                    st_d  = SEL_CFLUSH;
                    cur_d = pref_tid;
                end else if (cur_long && found) begin
                    st_d  = SEL_CFLUSH;
                    cur_d = pick;
                    rr_d  = tid_inc(pick);
                end
            end
            default: begin
                st_d = SEL_FINE;
            end
        endcase
    end

    // Output logic
    always_comb begin
        fetch_vld = 1'b0;
        fetch_tid = cur_q;
        flush_req = 1'b0;
        unique case (st_q)
            SEL_FINE: begin
                fetch_tid = rr_q;
                if (!mode_coarse) begin
                    if (pref_hit) begin
                        fetch_vld = 1'b1;
                        fetch_tid = pref_tid;
                    end else if (found) begin
                        fetch_vld = 1'b1;
                        fetch_tid = pick;
                    end
                end
            end
            SEL_CFLUSH: begin
                flush_req = 1'b1;
            end
            SEL_CRUN: begin
                if (mode_coarse && !pref_other && cur_ready) begin
                    fetch_vld = 1'b1;
                end
            end
            default: begin
                fetch_vld = 1'b0;
            end
        endcase
    end

    assign rr_ptr = rr_q;

    // R3: only a ready thread is ever fetched
    a_r3_fetch_ready: assert property (@(posedge clk) disable iff (rst)
        fetch_vld |-> ready[fetch_tid]);

    // R8: a flush lasts a single cycle
    a_r8_flush_single: assert property (@(posedge clk) disable iff (rst)
        flush_req |=> !flush_req);

    // R8: the cycle before a flush carries no fetch
    a_r8_flush_after_gap: assert property (@(posedge clk) disable iff (rst)
        flush_req |-> !$past(fetch_vld));

    // R2: with several ready threads, consecutive round-robin fetches differ
    a_r2_rotate: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && st_q == SEL_FINE && $past(st_q) == SEL_FINE &&
         fetch_vld && $past(fetch_vld) && !pref_en && !$past(pref_en) &&
         $countones(ready) > 1) |-> (fetch_tid != $past(fetch_tid)));

    // R4: an idle interleaved cycle leaves the pointer alone
    a_r4_ptr_hold: assert property (@(posedge clk) disable iff (rst)
        (st_q == SEL_FINE && !fetch_vld) |=> (rr_q == $past(rr_q)));

    // R10: preferred fetches do not move the pointer
    a_r10_pref_ptr: assert property (@(posedge clk) disable iff (rst)
        (st_q == SEL_FINE && !mode_coarse && pref_hit) |=> (rr_q == $past(rr_q)));

    // R7: block mode keeps issuing from one thread between switches
    a_r7_block_hold: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(st_q) == SEL_CRUN && $past(fetch_vld) && fetch_vld)
        |-> (fetch_tid == $past(fetch_tid)));

endmodule

// File: rtl/mt_fetch_sel.sv
module mt_fetch_sel #(
    parameter int unsigned     NUM_THR  = 4,
    parameter int unsigned     PC_W     = 32,
    parameter logic [PC_W-1:0] RESET_PC = 'h100,
    parameter int unsigned     PC_STEP  = 4,
    localparam int unsigned    TID_W    = $clog2(NUM_THR)
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    mode_coarse,
    input  logic                    pref_en,
    input  logic [TID_W-1:0]        pref_tid,
    input  logic [NUM_THR-1:0]      short_stall,
    input  logic [NUM_THR-1:0]      long_stall,
    input  logic [NUM_THR-1:0]      redir_vld,
    input  logic [NUM_THR*PC_W-1:0] redir_pc,
    output logic                    fetch_vld,
    output logic [TID_W-1:0]        fetch_tid,
    output logic [PC_W-1:0]         fetch_pc,
    output logic                    flush_req
);

    logic [NUM_THR-1:0] ready;
    logic [NUM_THR-1:0] excl;
    logic [NUM_THR-1:0] cand;
    logic [TID_W-1:0]   rr_ptr;
    logic [TID_W-1:0]   pick;
    logic               found;

    assign ready = ~(short_stall | long_stall);
    assign cand  = ready & ~excl;

    mtf_rr_pick #(
        .NUM_THR (NUM_THR),
        .TID_W   (TID_W)
    ) u_pick (
        .cand  (cand),
        .start (rr_ptr),
        .pick  (pick),
        .found (found)
    );

    mtf_ctrl #(
        .NUM_THR (NUM_THR),
        .TID_W   (TID_W)
    ) u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .mode_coarse (mode_coarse),
        .pref_en     (pref_en),
        .pref_tid    (pref_tid),
        .ready       (ready),
        .long_stall  (long_stall),
        .pick        (pick),
        .found       (found),
        .excl        (excl),
        .rr_ptr      (rr_ptr),
        .fetch_vld   (fetch_vld),
        .fetch_tid   (fetch_tid),
        .flush_req   (flush_req)
    );

    mtf_pc_bank #(
        .NUM_THR  (NUM_THR),
        .TID_W    (TID_W),
        .PC_W     (PC_W),
        .RESET_PC (RESET_PC),
        .PC_STEP  (PC_STEP)
    ) u_pcs (
        .clk       (clk),
        .rst       (rst),
        .fire      (fetch_vld),
        .fire_tid  (fetch_tid),
        .redir_vld (redir_vld),
        .redir_pc  (redir_pc),
        .rd_pc     (fetch_pc)
    );

endmodule

// File: tb/mt_fetch_sel_tb_top.sv
module mt_fetch_sel_tb_top;

    localparam int unsigned NT   = 4;
    localparam int unsigned PW   = 32;
    localparam logic [31:0] RVEC = 32'h100;

    logic           clk;
    logic           rst;
    logic           mode_coarse;
    logic           pref_en;
    logic [1:0]     pref_tid;
    logic [NT-1:0]  short_stall;
    logic [NT-1:0]  long_stall;
    logic [NT-1:0]  redir_vld;
    logic [NT*PW-1:0] redir_pc;
    logic           fetch_vld;
    logic [1:0]     fetch_tid;
    logic [PW-1:0]  fetch_pc;
    logic           flush_req;

    int n_tests = 0;
    int n_fail  = 0;
    logic [31:0] exp_pc [NT];

    mt_fetch_sel #(
        .NUM_THR  (NT),
        .PC_W     (PW),
        .RESET_PC (RVEC),
        .PC_STEP  (4)
    ) dut_i (
        .clk         (clk),
        .rst         (rst),
        .mode_coarse (mode_coarse),
        .pref_en     (pref_en),
        .pref_tid    (pref_tid),
        .short_stall (short_stall),
        .long_stall  (long_stall),
        .redir_vld   (redir_vld),
        .redir_pc    (redir_pc),
        .fetch_vld   (fetch_vld),
        .fetch_tid   (fetch_tid),
        .fetch_pc    (fetch_pc),
        .flush_req   (flush_req)
    );

    initial clk = 1'b0;
    always #4 clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Inputs are set just after a falling edge; checks follow 1 ns later.
    task automatic exp_fetch_at(input string req, input int tid, input logic [31:0] pc);
        #1;
        chk({req, " vld"}, 32'(fetch_vld), 32'd1);
        chk({req, " tid"}, 32'(fetch_tid), 32'(tid));
        chk({req, " pc"}, fetch_pc, pc);
        chk({req, " flush"}, 32'(flush_req), 32'd0);
        exp_pc[tid] = pc + 32'd4;
        @(negedge clk);
    endtask

    task automatic exp_fetch(input string req, input int tid);
        exp_fetch_at(req, tid, exp_pc[tid]);
    endtask

    task automatic exp_idle(input string req, input logic flush_exp);
        #1;
        chk({req, " vld"}, 32'(fetch_vld), 32'd0);
        chk({req, " flush"}, 32'(flush_req), 32'(flush_exp));
        @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst         = 1'b1;
        mode_coarse = 1'b0;
        pref_en     = 1'b0;
        pref_tid    = 2'd0;
        short_stall = '0;
        long_stall  = '0;
        redir_vld   = '0;
        redir_pc    = '0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        for (int i = 0; i < NT; i++) exp_pc[i] = RVEC;
    endtask

    task automatic enter_coarse(input string req);
        mode_coarse = 1'b1;
        exp_idle(req, 1'b0);
        exp_idle(req, 1'b1);
    endtask

    task automatic t_reset();
        do_reset();
        #1;
        chk("R1 flush after reset", 32'(flush_req), 32'd0);
        exp_fetch_at("R1 first fetch", 0, RVEC);
    endtask

    task automatic t_rotate();
        do_reset();
        exp_fetch("R2 rr", 0);
        exp_fetch("R2 rr", 1);
        exp_fetch("R2 rr", 2);
        exp_fetch("R2 rr", 3);
        exp_fetch("R5 step t0", 0);
        exp_fetch("R5 step t1", 1);
    endtask

    task automatic t_skip();
        do_reset();
        short_stall[1] = 1'b1;
        long_stall[2]  = 1'b1;
        exp_fetch("R3 skip", 0);
        exp_fetch("R3 skip", 3);
        exp_fetch("R3 skip", 0);
        exp_fetch("R3 skip", 3);
        short_stall = '0;
        long_stall  = '0;
        exp_fetch("R3 unstall", 0);
        exp_fetch("R3 unstall", 1);
    endtask

    task automatic t_allstall();
        do_reset();
        exp_fetch("R4 before", 0);
        short_stall = 4'hF;
        exp_idle("R4 none ready", 1'b0);
        short_stall = 4'h0;
        long_stall  = 4'hF;
        exp_idle("R4 none ready", 1'b0);
        long_stall = 4'h0;
        exp_fetch("R4 pointer held", 1);
    endtask

    task automatic t_redirect();
        do_reset();
        redir_vld[0]       = 1'b1;
        redir_pc[0*PW +: PW] = 32'h2000;
        exp_fetch_at("R6 redirect beats step", 0, 32'h2000);
        redir_vld            = 4'b1000;
        redir_pc[3*PW +: PW] = 32'h3000;
        exp_fetch("R6 other thread", 1);
        redir_vld = '0;
        exp_pc[3] = 32'h3000;
        exp_fetch("R5 t2", 2);
        exp_fetch("R6 unfetched redirect kept", 3);
        exp_fetch("R6 redirect then step", 0);
    endtask

    task automatic t_coarse();
        do_reset();
        enter_coarse("R7 enter");
        exp_fetch("R7 run", 0);
        exp_fetch("R7 run", 0);
        short_stall[0] = 1'b1;
        exp_idle("R7 short stall waits", 1'b0);
        short_stall[0] = 1'b0;
        exp_fetch("R7 resume", 0);
        long_stall[0] = 1'b1;
        exp_idle("R8 decide", 1'b0);
        exp_idle("R8 flush", 1'b1);
        exp_fetch("R8 new thread", 1);
        exp_fetch("R8 flush once", 1);
    endtask

    task automatic t_coarse_wait();
        do_reset();
        enter_coarse("R9 enter");
        exp_fetch("R9 run", 0);
        long_stall = 4'hF;
        exp_idle("R9 wait", 1'b0);
        exp_idle("R9 wait", 1'b0);
        long_stall = 4'b1110;
        exp_fetch("R9 same thread resumes", 0);
    endtask

    task automatic t_pref_fine();
        do_reset();
        pref_en  = 1'b1;
        pref_tid = 2'd2;
        exp_fetch("R10 pref", 2);
        exp_fetch("R10 pref", 2);
        exp_fetch("R10 pref", 2);
        short_stall[2] = 1'b1;
        exp_fetch("R10 pref stalled, pointer at 0", 0);
        exp_fetch("R10 pref stalled", 1);
        short_stall[2] = 1'b0;
        exp_fetch("R10 pref back", 2);
    endtask

    task automatic t_pref_coarse();
        do_reset();
        enter_coarse("R11 enter");
        exp_fetch("R11 run", 0);
        pref_en  = 1'b1;
        pref_tid = 2'd3;
        exp_idle("R11 decide", 1'b0);
        exp_idle("R11 flush", 1'b1);
        exp_fetch("R11 pref runs", 3);
        exp_fetch("R11 pref keeps", 3);
    endtask

    initial begin
        #(8 * 200000);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        rst         = 1'b1;
        mode_coarse = 1'b0;
        pref_en     = 1'b0;
        pref_tid    = 2'd0;
        short_stall = '0;
        long_stall  = '0;
        redir_vld   = '0;
        redir_pc    = '0;
        t_reset();
        t_rotate();
        t_skip();
        t_allstall();
        t_redirect();
        t_coarse();
        t_coarse_wait();
        t_pref_fine();
        t_pref_coarse();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule